// File: doc/BRIEF.md
# Parallel Host Bus Slave

This block lets an asynchronous, microprocessor-style host read and write a chip's internal registers over a parallel bus. Every host pin is passed through a two-flop synchroniser into the internal clock domain. Accesses are found from edges of the synchronised strobes, and only while the active-low chip select is low. Two strobe styles can be chosen at run time. In the first, separate read and write strobes are used. In the second, a data strobe is paired with a direction line. The data path can be one 16-bit word per access, or one byte per access with two accesses forming a word. The byte order can be swapped in either width.

Host writes become single-cycle register write requests carrying address and word. A write to the command address is a read command: it is passed on as a request and marks read data as pending. Reads of the data address return the word offered by an internal read-data queue, and the word is popped when its last byte has been read. Reads of the status address report the pending flag and the queue's valid flag. A wait output, with a programmable active level, stretches any read whose data is not ready. This includes a status read made between a read command and its data.

Top module: `hostBusSlave`

## Requirements
- R1: No access of any kind is recognised while busCsN is high; strobes toggled with chip select inactive produce no request.
- R2: In separate-strobe mode (cfgCombo=0), a low pulse on busWrRwN is a write. Address and data are taken as they stood just before the strobe (or chip select) rose, and exactly one regWrValid pulse of one cycle carries them.
- R3: In combined mode (cfgCombo=1), busRdDsN is the data strobe and busWrRwN is the direction: 1 means read, 0 means write.
- R4: In 16-bit mode (cfgWide=1), each access moves a whole word. With cfgSwap=1, bits [15:8] and [7:0] are exchanged on both write data and read data.
- R5: In 8-bit mode (cfgWide=0), two byte accesses on busDataIn/busDataOut [7:0] at the same address form one word. The first byte goes to the low half (the high half when cfgSwap=1). A write request is issued only after the second byte, and bits [15:8] of busDataOut read as zero.
- R6: The byte pointer returns to the first byte whenever an access uses an address that differs from the previous access.
- R7: Address 0 is status, address 1 is data, and address 2 is the read command. A write to address 2 is issued as a request and sets pending. A status read returns bit0 = pending, bit1 = read-data valid, and zeros elsewhere.
- R8: The wait output is active while chip select is active, a command is pending and no read data is valid. It is also active while the data address is being read with no valid data. It releases once data is valid, and busDataOut carries that data by the cycle the wait releases.
- R9: busWait is high when active if cfgWaitHigh=1, and low when active otherwise. With cfgWaitEn=0 it is held at the inactive level.
- R10: A data read returns rdWord. rdPop pulses once, at the end of the last-byte read of a valid word, and clears pending.
- R11: After reset, busWait is at its inactive level, busDataOe is 0 and no request has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCombo | input | 1 | 1 selects data strobe plus direction line |
| cfgWide | input | 1 | 1 selects 16-bit accesses, 0 selects 8-bit |
| cfgSwap | input | 1 | Exchange the two bytes of each word |
| cfgWaitEn | input | 1 | Enable the wait output |
| cfgWaitHigh | input | 1 | Active level of the wait output |
| busCsN | input | 1 | Chip select, active low |
| busRdDsN | input | 1 | Read strobe, or data strobe in combined mode |
| busWrRwN | input | 1 | Write strobe, or direction (1 = read) in combined mode |
| busAddr | input | ADDR_W | Host address |
| busDataIn | input | DATA_W | Host write data |
| busDataOut | output | DATA_W | Read data to the host |
| busDataOe | output | 1 | Read data drive enable |
| busWait | output | 1 | Wait strobe |
| regWrValid | output | 1 | One-cycle register write request |
| regWrAddr | output | ADDR_W | Address of the request |
| regWrData | output | DATA_W | Word of the request |
| rdWord | input | DATA_W | Head word of the read-data queue |
| rdWordValid | input | 1 | Head word is valid |
| rdPop | output | 1 | Head word consumed |

## Verification
The bench goes after the byte pointer in three ways: a lone byte written to one address, then a byte pair at another. A design that does not reset the pointer merges the stray byte into the wrong word. It also issues a status read between a read command and its data. A wait that only watches the data address would let that read finish early, with the pending bit showing but no data behind it. Swap is checked in both widths and both directions, so a swap applied only to writes, or only in one width, returns mirrored bytes. The wait level is checked with both polarities and with the output disabled while data is pending, which catches a wait whose polarity is inverted or that is stuck active.

// File: rtl/hbsPkg.sv
package hbsPkg;
  // Strobes and state handed from the control module to the datapath
  typedef struct packed {
    logic capture;     // write access ended: take the byte/word
    logic commit;      // word complete: issue request
    logic hiLane;      // byte lane of the current 8-bit access
    logic reading;     // read access in progress
    logic rdIsStatus;  // read targets the status address
    logic pending;     // read command outstanding
  } hbsStrbT;
endpackage

// File: rtl/hbsCtrl.sv
module hbsCtrl
  import hbsPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int DATA_ADDR   = 1,
  parameter int CMD_ADDR    = 2,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busRdDsN,
  input  logic              busWrRwN,
  input  logic              cfgCombo,
  input  logic              cfgWide,
  input  logic              cfgSwap,
  input  logic              cfgWaitEn,
  input  logic              cfgWaitHigh,
  input  logic [ADDR_W-1:0] addrNow,
  input  logic [ADDR_W-1:0] addrPrev,
  input  logic              rdWordValid,
  output hbsStrbT           strb,
  output logic              busWait,
  output logic              rdPop
);
  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] DataA   = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] CmdA    = ADDR_W'(CMD_ADDR);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] csS, rdS, wrS;
  logic csAct, accNow, accPrev, kindRead, accStart, accEnd;
  logic reading, inWrite, pending, ptr, rdPtr, hiLaneQ;
  logic [ADDR_W-1:0] rdAddr, lastAddr;
  logic curPtrNow, curPtrPrev, wrEnd, rdEnd, commit, popNow, waitNeed;

  // Synchronised pin view and access decode
  assign csAct    = !csS[LAST];
  assign accNow   = csAct && (cfgCombo ? !rdS[LAST] : (!rdS[LAST] || !wrS[LAST]));
  assign kindRead = cfgCombo ? wrS[LAST] : !rdS[LAST];
  assign accStart = accNow && !accPrev;
  assign accEnd   = !accNow && accPrev;
  assign wrEnd    = accEnd && inWrite;
  assign rdEnd    = accEnd && reading;

  // Byte pointer falls back to the first byte on an address change
  assign curPtrNow  = (addrNow == lastAddr) ? ptr : 1'b0;
  assign curPtrPrev = (addrPrev == lastAddr) ? ptr : 1'b0;

  assign commit   = wrEnd && (cfgWide || curPtrPrev);
  assign popNow   = rdEnd && (rdAddr == DataA) && (cfgWide || rdPtr) && rdWordValid;
  assign waitNeed = (csAct && pending && !rdWordValid) ||
                    (reading && (rdAddr == DataA) && !rdWordValid);

  always_comb begin
    strb.capture    = wrEnd;
    strb.commit     = commit;
    strb.hiLane     = wrEnd ? (!cfgWide && (curPtrPrev ^ cfgSwap)) : hiLaneQ;
    strb.reading    = reading;
    strb.rdIsStatus = (rdAddr == StatusA);
    strb.pending    = pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS      <= '1;
      rdS      <= '1;
      wrS      <= '1;
      accPrev  <= 1'b0;
      reading  <= 1'b0;
      inWrite  <= 1'b0;
      rdAddr   <= '0;
      lastAddr <= '1;
      ptr      <= 1'b0;
      rdPtr    <= 1'b0;
      hiLaneQ  <= 1'b0;
      pending  <= 1'b0;
      rdPop    <= 1'b0;
      busWait  <= !cfgWaitHigh;
    end else begin
      csS     <= {csS[SYNC_DEPTH-2:0], busCsN};
      rdS     <= {rdS[SYNC_DEPTH-2:0], busRdDsN};
      wrS     <= {wrS[SYNC_DEPTH-2:0], busWrRwN};
      accPrev <= accNow;
      rdPop   <= popNow;
      if (accStart && kindRead) begin
        reading  <= 1'b1;
        rdAddr   <= addrNow;
        rdPtr    <= curPtrNow;
        hiLaneQ  <= !cfgWide && (curPtrNow ^ cfgSwap);
        lastAddr <= addrNow;
      end else if (accStart) begin
        inWrite <= 1'b1;
      end
      if (rdEnd) begin
        reading <= 1'b0;
        ptr     <= !cfgWide && !rdPtr;
      end
      if (wrEnd) begin
        inWrite  <= 1'b0;
        lastAddr <= addrPrev;
        ptr      <= !cfgWide && !curPtrPrev;
      end
      if (popNow) pending <= 1'b0;
      else if (commit && (addrPrev == CmdA)) pending <= 1'b1;
      busWait <= (cfgWaitEn && waitNeed) ? cfgWaitHigh : !cfgWaitHigh;
    end
  end

  AST_WAIT_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWaitEn) |-> (busWait == !$past(cfgWaitHigh))); // R9
  AST_POP_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    rdPop |-> !pending); // R10
  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> $past(csAct)); // R1
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(reading && inWrite)); // R3
endmodule

// File: rtl/hbsData.sv
module hbsData
  import hbsPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  input  hbsStrbT           strb,
  input  logic              cfgWide,
  input  logic              cfgSwap,
  input  logic [DATA_W-1:0] rdWord,
  input  logic              rdWordValid,
  output logic [ADDR_W-1:0] addrNow,
  output logic [ADDR_W-1:0] addrPrev,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              regWrValid,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData
);
  localparam int HALF   = DATA_W / 2;
  localparam int STAGES = SYNC_DEPTH + 1;

  logic [ADDR_W-1:0] aPipe [STAGES];
  logic [DATA_W-1:0] dPipe [STAGES];
  logic [DATA_W-1:0] wordBuf, nextWord, dataPrev, srcWord, outWord, statusWord;

  function automatic logic [DATA_W-1:0] swapBytes(input logic [DATA_W-1:0] w);
    return {w[HALF-1:0], w[DATA_W-1:HALF]};
  endfunction

  // Address/data delay line aligned with the strobe synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPipe[0] <= '0;
      dPipe[0] <= '0;
    end else begin
      aPipe[0] <= busAddr;
      dPipe[0] <= busDataIn;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aPipe[s] <= '0;
        dPipe[s] <= '0;
      end else begin
        aPipe[s] <= aPipe[s-1];
        dPipe[s] <= dPipe[s-1];
      end
    end
  end

  assign addrNow  = aPipe[SYNC_DEPTH-1];
  assign addrPrev = aPipe[SYNC_DEPTH];
  assign dataPrev = dPipe[SYNC_DEPTH];

  // Write word assembly
  always_comb begin
    if (cfgWide)
      nextWord = cfgSwap ? swapBytes(dataPrev) : dataPrev;
    else if (strb.hiLane)
      nextWord = {dataPrev[HALF-1:0], wordBuf[HALF-1:0]};
    else
      nextWord = {wordBuf[DATA_W-1:HALF], dataPrev[HALF-1:0]};
  end

  // Read word selection
  assign statusWord = {{(DATA_W-2){1'b0}}, rdWordValid, strb.pending};
  assign srcWord    = strb.rdIsStatus ? statusWord : rdWord;
  always_comb begin
    if (cfgWide)
      outWord = cfgSwap ? swapBytes(srcWord) : srcWord;
    else
      outWord = {{HALF{1'b0}}, strb.hiLane ? srcWord[DATA_W-1:HALF] : srcWord[HALF-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordBuf    <= '0;
      regWrValid <= 1'b0;
      regWrAddr  <= '0;
      regWrData  <= '0;
      busDataOut <= '0;
      busDataOe  <= 1'b0;
    end else begin
      if (strb.capture) wordBuf <= nextWord;
      regWrValid <= strb.commit;
      if (strb.commit) begin
        regWrAddr <= addrPrev;
        regWrData <= nextWord;
      end
      busDataOe  <= strb.reading;
      busDataOut <= strb.reading ? outWord : '0;
    end
  end

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |=> !regWrValid); // R2
endmodule

// File: rtl/hostBusSlave.sv
module hostBusSlave
  import hbsPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int STATUS_ADDR = 0,
  parameter int DATA_ADDR   = 1,
  parameter int CMD_ADDR    = 2,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCombo,
  input  logic              cfgWide,
  input  logic              cfgSwap,
  input  logic              cfgWaitEn,
  input  logic              cfgWaitHigh,
  input  logic              busCsN,
  input  logic              busRdDsN,
  input  logic              busWrRwN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              busWait,
  output logic              regWrValid,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rdWord,
  input  logic              rdWordValid,
  output logic              rdPop
);
  hbsStrbT strb;
  logic [ADDR_W-1:0] addrNow, addrPrev;

  hbsCtrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR),
    .CMD_ADDR(CMD_ADDR), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busCsN(busCsN), .busRdDsN(busRdDsN), .busWrRwN(busWrRwN),
    .cfgCombo(cfgCombo), .cfgWide(cfgWide), .cfgSwap(cfgSwap),
    .cfgWaitEn(cfgWaitEn), .cfgWaitHigh(cfgWaitHigh),
    .addrNow(addrNow), .addrPrev(addrPrev), .rdWordValid(rdWordValid),
    .strb(strb), .busWait(busWait), .rdPop(rdPop)
  );

  hbsData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busDataIn(busDataIn), .strb(strb),
    .cfgWide(cfgWide), .cfgSwap(cfgSwap),
    .rdWord(rdWord), .rdWordValid(rdWordValid),
    .addrNow(addrNow), .addrPrev(addrPrev),
    .busDataOut(busDataOut), .busDataOe(busDataOe),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData)
  );
endmodule

// File: tb/hostBusSlave_bench.sv
module hostBusSlave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCombo = 1'b0, cfgWide = 1'b1, cfgSwap = 1'b0;
  logic cfgWaitEn = 1'b1, cfgWaitHigh = 1'b0;
  logic busCsN = 1'b1, busRdDsN = 1'b1, busWrRwN = 1'b1;
  logic [3:0]  busAddr = '0;
  logic [15:0] busDataIn = '0;
  logic [15:0] busDataOut;
  logic        busDataOe, busWait, regWrValid, rdPop;
  logic [3:0]  regWrAddr;
  logic [15:0] regWrData;
  logic [15:0] rdWord = '0;
  logic        rdWordValid = 1'b0;

  int total = 0, bad = 0;
  int wrCount = 0, popCount = 0;
  logic [3:0]  lastWrAddr = '0;
  logic [15:0] lastWrData = '0;

  always #5 clk = !clk;

  hostBusSlave u_hostBusSlave (
    .clk(clk), .rstN(rstN),
    .cfgCombo(cfgCombo), .cfgWide(cfgWide), .cfgSwap(cfgSwap),
    .cfgWaitEn(cfgWaitEn), .cfgWaitHigh(cfgWaitHigh),
    .busCsN(busCsN), .busRdDsN(busRdDsN), .busWrRwN(busWrRwN),
    .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busWait(busWait),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .rdWord(rdWord), .rdWordValid(rdWordValid), .rdPop(rdPop)
  );

  always @(posedge clk) begin
    if (rstN && regWrValid) begin
      wrCount    <= wrCount + 1;
      lastWrAddr <= regWrAddr;
      lastWrData <= regWrData;
    end
    if (rstN && rdPop) popCount <= popCount + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic waitActive();
    return busWait == cfgWaitHigh;
  endfunction

  task automatic hostWrite(input logic [3:0] a, input logic [15:0] d, input logic useCs);
    @(negedge clk);
    busCsN = !useCs; busAddr = a; busDataIn = d;
    if (cfgCombo) busWrRwN = 1'b0;
    @(negedge clk);
    if (cfgCombo) busRdDsN = 1'b0; else busWrRwN = 1'b0;
    repeat (6) @(negedge clk);
    if (cfgCombo) busRdDsN = 1'b1; else busWrRwN = 1'b1;
    @(negedge clk);
    busWrRwN = 1'b1; busCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic startRead(input logic [3:0] a);
    @(negedge clk);
    busCsN = 1'b0; busAddr = a; busWrRwN = 1'b1;
    @(negedge clk);
    busRdDsN = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finishRead(output logic [15:0] v);
    for (int i = 0; i < 100 && waitActive(); i++) @(negedge clk);
    repeat (2) @(negedge clk);
    v = busDataOut;
    busRdDsN = 1'b1;
    @(negedge clk);
    busCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [15:0] v);
    startRead(a);
    finishRead(v);
  endtask

  task automatic tReset();
    check("R11 wait idle after reset", busWait, 1'b1);
    check("R11 oe low after reset", busDataOe, 1'b0);
    check("R11 no request after reset", wrCount, 0);
  endtask

  task automatic tWideWrite();
    int base;
    cfgWide = 1'b1; cfgSwap = 1'b0; base = wrCount;
    hostWrite(4'd5, 16'hA1B2, 1'b1);
    check("R2 one request", wrCount, base + 1);
    check("R2 address", lastWrAddr, 4'd5);
    check("R4 word", lastWrData, 16'hA1B2);
    cfgSwap = 1'b1;
    hostWrite(4'd6, 16'h1234, 1'b1);
    check("R4 swapped write", lastWrData, 16'h3412);
    cfgSwap = 1'b0;
  endtask

  task automatic tNarrowWrite();
    int base;
    cfgWide = 1'b0; cfgSwap = 1'b0; base = wrCount;
    hostWrite(4'd7, 16'h0034, 1'b1);
    check("R5 no request after first byte", wrCount, base);
    hostWrite(4'd7, 16'h0012, 1'b1);
    check("R5 one request per byte pair", wrCount, base + 1);
    check("R5 low then high", lastWrData, 16'h1234);
    cfgSwap = 1'b1;
    hostWrite(4'd8, 16'h0012, 1'b1);
    hostWrite(4'd8, 16'h0034, 1'b1);
    check("R5 swapped high then low", lastWrData, 16'h1234);
    cfgSwap = 1'b0;
  endtask

  task automatic tPtrReset();
    int base;
    cfgWide = 1'b0; cfgSwap = 1'b0; base = wrCount;
    hostWrite(4'd9, 16'h00EE, 1'b1);
    hostWrite(4'd10, 16'h0078, 1'b1);
    hostWrite(4'd10, 16'h0056, 1'b1);
    check("R6 single request", wrCount, base + 1);
    check("R6 address", lastWrAddr, 4'd10);
    check("R6 stray byte dropped", lastWrData, 16'h5678);
  endtask

  task automatic tCsGate();
    int base;
    cfgWide = 1'b1; base = wrCount;
    hostWrite(4'd4, 16'h5555, 1'b0);
    check("R1 no request without chip select", wrCount, base);
  endtask

  task automatic tComboWrite();
    int base;
    cfgCombo = 1'b1; cfgWide = 1'b1; base = wrCount;
    hostWrite(4'd3, 16'hBEEF, 1'b1);
    check("R3 combined write request", wrCount, base + 1);
    check("R3 combined write data", lastWrData, 16'hBEEF);
    cfgCombo = 1'b0;
  endtask

  task automatic tCmdStatus();
    logic [15:0] v;
    int pops;
    cfgWide = 1'b1; cfgSwap = 1'b0; rdWordValid = 1'b0;
    hostWrite(4'd2, 16'h0042, 1'b1);
    check("R7 command issued as request", lastWrAddr, 4'd2);
    startRead(4'd0);
    check("R8 status read stretched", waitActive(), 1'b1);
    rdWord = 16'hCAFE; rdWordValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 wait released", waitActive(), 1'b0);
    check("R7 status pending and valid", busDataOut, 16'h0003);
    finishRead(v);
    pops = popCount;
    hostRead(4'd1, v);
    check("R10 data word", v, 16'hCAFE);
    check("R10 one pop", popCount, pops + 1);
    rdWordValid = 1'b0;
    hostRead(4'd0, v);
    check("R10 pending cleared", v, 16'h0000);
  endtask

  task automatic tNarrowRead();
    logic [15:0] v;
    int pops;
    cfgWide = 1'b0; cfgSwap = 1'b0;
    rdWord = 16'h9A5B; rdWordValid = 1'b1; pops = popCount;
    hostRead(4'd1, v);
    check("R5 first byte low", v, 16'h005B);
    check("R10 no pop mid word", popCount, pops);
    hostRead(4'd1, v);
    check("R5 second byte high", v, 16'h009A);
    check("R10 pop after last byte", popCount, pops + 1);
    cfgSwap = 1'b1;
    hostRead(4'd1, v);
    check("R5 swapped first byte high", v, 16'h009A);
    hostRead(4'd1, v);
    check("R5 swapped second byte low", v, 16'h005B);
    cfgWide = 1'b1;
    hostRead(4'd1, v);
    check("R4 swapped wide read", v, 16'h5B9A);
    cfgSwap = 1'b0; rdWordValid = 1'b0;
  endtask

  task automatic tWaitPol();
    logic [15:0] v;
    cfgWide = 1'b1;
    @(negedge clk); cfgWaitHigh = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 idle level with high polarity", busWait, 1'b0);
    hostWrite(4'd2, 16'h0001, 1'b1);
    startRead(4'd0);
    check("R9 active high wait", busWait, 1'b1);
    cfgWaitEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 disabled wait inactive", busWait, 1'b0);
    cfgWaitEn = 1'b1; rdWord = 16'h1111; rdWordValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 wait released with data", busWait, 1'b0);
    finishRead(v);
    hostRead(4'd1, v);
    check("R10 data after release", v, 16'h1111);
    rdWordValid = 1'b0;
    cfgWaitHigh = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 idle level with low polarity", busWait, 1'b1);
  endtask

  task automatic tComboRead();
    logic [15:0] v;
    cfgCombo = 1'b1; cfgWide = 1'b1; cfgSwap = 1'b0;
    rdWord = 16'h7E57; rdWordValid = 1'b1;
    hostRead(4'd1, v);
    check("R3 combined read", v, 16'h7E57);
    rdWordValid = 1'b0; cfgCombo = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tWideWrite();
    tNarrowWrite();
    tPtrReset();
    tCsGate();
    tComboWrite();
    tCmdStatus();
    tNarrowRead();
    tWaitPol();
    tComboRead();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule